// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block sits between a 32.768 kHz timebase and a calendar counter. It counts input pulses, presented as a one-cycle `tickIn` qualifier in the host clock domain, and produces a one-cycle pulse at each half-second and each full second. It also provides a level that shows which half of the second is running, and a square-wave seconds clock.

Crystal error is corrected once per minute. A signed 8-bit trim code is multiplied by four. At each minute boundary, a positive result makes the prescaler restart the new second partway through, which shortens that second. A negative result makes the prescaler swallow that many input pulses before it counts again, which lengthens that second. The trim code is sampled only at the boundary.

Software can zero every prescaler stage with a synchronisation strobe, which is raised when the minutes/seconds register is written. Clearing the enable input holds all stages at zero. A power-on reset is the only other reset.

Top module: `cal_sec_prescaler`

## Requirements
- R1: With a trim code of 0 and `tickIn` high in every cycle, `secTick` is a one-cycle pulse. It appears every PULSES_PER_SEC accepted input pulses. The first pulse follows PULSES_PER_SEC pulses after a clear.
- R2: `halfSec` is 0 while the count within the second is below PULSES_PER_SEC/2 and 1 from that point on. `halfTick` pulses for one cycle as the count reaches PULSES_PER_SEC/2.
- R3: `secClk` is high in the first half of each second and low in the second half. It is high in the cycle where `secTick` is asserted.
- R4: `calValue` is two's complement, and the adjustment is four times its value. For a positive code c, the second that begins at each minute boundary starts at count 4c, so it lasts PULSES_PER_SEC-4c pulses (0x7F gives 508, 0x01 gives 4).
- R5: For a negative code c, the first 4|c| input pulses after each minute boundary are ignored, so that second lasts PULSES_PER_SEC+4|c| pulses (0xFF gives 4, 0x80 gives 512).
- R6: `calValue` is sampled only at the minute boundary, which is the wrap that ends every SEC_PER_MIN-th second after a clear. A change made in the middle of a minute leaves the seconds before that boundary unchanged.
- R7: `syncClear` zeroes the pulse count, the half-second state, the second-of-minute count and any pending swallow. A new second of full length then starts.
- R8: While `enable` is 0, every stage is held at zero, `halfSec` stays 0 and no ticks appear. Counting starts from zero when `enable` returns to 1.
- R9: A cycle with `tickIn` low does not advance the prescaler. With `tickIn` high in every other cycle, a second lasts 2×PULSES_PER_SEC cycles.
- R10: After the power-on reset `rst_n`, `secTick` and `halfTick` are 0, `halfSec` is 0 and `secClk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| enable | input | 1 | Module enable; 0 holds the prescaler cleared |
| syncClear | input | 1 | One-cycle strobe from a write to the minutes/seconds register |
| tickIn | input | 1 | Input-pulse qualifier, one per 32.768 kHz period |
| calValue | input | CAL_W | Signed trim code, sampled at minute boundaries |
| secTick | output | 1 | One-cycle pulse at the start of each second |
| halfTick | output | 1 | One-cycle pulse at the middle of each second |
| halfSec | output | 1 | 1 during the second half of a second |
| secClk | output | 1 | 50% duty seconds clock, high in the first half |

## Verification
The bench measures the cycle distance between consecutive `secTick` pulses and compares each distance with a queue of expected lengths. It does this first at a nominal trim code, and then at the smallest and largest positive and negative codes. These runs show that the adjustment lands only on the second after every third wrap, and that it has the right sign and size. Further runs change the code mid-minute, clear the block mid-second and during a pending swallow, drop `enable` for several thousand cycles, and feed `tickIn` at half rate. Each of these tells a correct boundary sample, a full clear and a pulse-qualified count apart from a design that counts cycles or applies the trim at once. A direct probe around the count of half a second checks that `halfSec`, `halfTick` and `secClk` change on the same edge.

// File: rtl/cal_sec_pkg.sv
package cal_sec_pkg;

  // Strobes from the control to the count datapath
  typedef struct packed {
    logic clear;      // zero all prescaler stages
    logic step;       // accept one input pulse into the count
    logic minuteLast; // current second is the last of the minute
  } psStrobe_t;

endpackage

// File: rtl/cal_sec_ctrl.sv
module cal_sec_ctrl
  import cal_sec_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_W       = 8,
  parameter int CAL_SHIFT   = 2,
  localparam int SEC_W      = $clog2(SEC_PER_MIN),
  localparam int ADJ_W      = CAL_W + CAL_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             syncClear,
  input  logic             tickIn,
  input  logic [CAL_W-1:0] calValue,
  input  logic             wrapNow,
  output psStrobe_t        strobes,
  output logic [ADJ_W-1:0] advance
);

  logic [SEC_W-1:0] secCnt;
  logic [ADJ_W-1:0] holdCnt;
  logic             clearNow;
  logic             calNeg;
  logic [CAL_W-1:0] calMag;
  logic [ADJ_W-1:0] calScaled;
  logic             secLast;

  assign clearNow  = !enable || syncClear;
  assign calNeg    = calValue[CAL_W-1];
  assign calMag    = calNeg ? (~calValue + CAL_W'(1)) : calValue;
  assign calScaled = {calMag, {CAL_SHIFT{1'b0}}};
  assign secLast   = (secCnt == SEC_W'(SEC_PER_MIN - 1));

  always_comb begin
    strobes.clear      = clearNow;
    strobes.step       = tickIn && !clearNow && (holdCnt == '0);
    strobes.minuteLast = secLast;
    advance            = calNeg ? '0 : calScaled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secCnt  <= '0;
      holdCnt <= '0;
    end else if (clearNow) begin
      secCnt  <= '0;
      holdCnt <= '0;
    end else if (tickIn) begin
      if (holdCnt != '0) begin
        holdCnt <= holdCnt - ADJ_W'(1);
      end else if (wrapNow) begin
        if (secLast) begin
          secCnt  <= '0;
          holdCnt <= calNeg ? calScaled : '0;
        end else begin
          secCnt <= secCnt + SEC_W'(1);
        end
      end
    end
  end

  // R5: a pending swallow shrinks by one per accepted input pulse
  assert_hold_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(holdCnt) != '0 && $past(tickIn) && !$past(clearNow))
      |-> holdCnt == $past(holdCnt) - ADJ_W'(1));

  // R6: a swallow is only armed on the wrap that closes a minute
  assert_hold_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(holdCnt) == '0 && holdCnt != '0)
      |-> $past(tickIn && wrapNow && secLast && !clearNow));

  // R7: clearing drops any pending swallow
  assert_clear_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clearNow |=> holdCnt == '0);

endmodule

// File: rtl/cal_sec_datapath.sv
module cal_sec_datapath
  import cal_sec_pkg::*;
#(
  parameter int PULSES_PER_SEC = 32768,
  parameter int ADJ_W          = 10,
  localparam int CNT_W         = $clog2(PULSES_PER_SEC),
  localparam int HALF          = PULSES_PER_SEC / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psStrobe_t        strobes,
  input  logic [ADJ_W-1:0] advance,
  output logic             wrapNow,
  output logic             secTick,
  output logic             halfTick,
  output logic             halfSec,
  output logic             secClk
);

  logic [CNT_W-1:0] cnt;

  assign wrapNow = (cnt == CNT_W'(PULSES_PER_SEC - 1));
  assign halfSec = (cnt >= CNT_W'(HALF));
  assign secClk  = !halfSec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      secTick  <= 1'b0;
      halfTick <= 1'b0;
    end else begin
      secTick  <= 1'b0;
      halfTick <= 1'b0;
      if (strobes.clear) begin
        cnt <= '0;
      end else if (strobes.step) begin
        if (wrapNow) begin
          cnt     <= strobes.minuteLast ? CNT_W'(advance) : '0;
          secTick <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(HALF - 1)) halfTick <= 1'b1;
        end
      end
    end
  end

  // R1: the count never leaves the range of one second
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PULSES_PER_SEC - 1));

  // R1: a seconds pulse only follows an accepted pulse on the last count
  assert_sec_after_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    secTick |-> ($past(strobes.step) && $past(cnt) == CNT_W'(PULSES_PER_SEC - 1)));

  // R2: the half pulse coincides with entering the second half
  assert_half_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halfTick |-> (halfSec && $past(!halfSec)));

  // R7: a clear leaves the count at zero on the next edge
  assert_clear_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (cnt == '0 && !secTick && !halfTick));

endmodule

// File: rtl/cal_sec_prescaler.sv
module cal_sec_prescaler
  import cal_sec_pkg::*;
#(
  parameter int PULSES_PER_SEC = 32768,
  parameter int SEC_PER_MIN    = 60,
  parameter int CAL_W          = 8,
  parameter int CAL_SHIFT      = 2,
  localparam int ADJ_W         = CAL_W + CAL_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             syncClear,
  input  logic             tickIn,
  input  logic [CAL_W-1:0] calValue,
  output logic             secTick,
  output logic             halfTick,
  output logic             halfSec,
  output logic             secClk
);

  psStrobe_t        strobes;
  logic [ADJ_W-1:0] advance;
  logic             wrapNow;

  cal_sec_ctrl #(
    .SEC_PER_MIN (SEC_PER_MIN),
    .CAL_W       (CAL_W),
    .CAL_SHIFT   (CAL_SHIFT)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .syncClear (syncClear),
    .tickIn    (tickIn),
    .calValue  (calValue),
    .wrapNow   (wrapNow),
    .strobes   (strobes),
    .advance   (advance)
  );

  cal_sec_datapath #(
    .PULSES_PER_SEC (PULSES_PER_SEC),
    .ADJ_W          (ADJ_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .advance  (advance),
    .wrapNow  (wrapNow),
    .secTick  (secTick),
    .halfTick (halfTick),
    .halfSec  (halfSec),
    .secClk   (secClk)
  );

  // R8: nothing ticks while disabled
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!secTick && !halfTick && !halfSec));

endmodule

// File: tb/test_cal_sec_prescaler.sv
module test_cal_sec_prescaler;

  localparam int P = 1024;
  localparam int S = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       syncClear = 1'b0;
  logic       tickIn = 1'b1;
  logic [7:0] calValue = 8'h00;
  logic       secTick, halfTick, halfSec, secClk;

  bit halfRate = 1'b0;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastMark = 0;
  int expQ[$];

  always #2 clk = ~clk;

  cal_sec_prescaler #(
    .PULSES_PER_SEC (P),
    .SEC_PER_MIN    (S)
  ) i_cal_sec_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .syncClear (syncClear),
    .tickIn    (tickIn),
    .calValue  (calValue),
    .secTick   (secTick),
    .halfTick  (halfTick),
    .halfSec   (halfSec),
    .secClk    (secClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) tickIn = halfRate ? ~tickIn : 1'b1;

  // Monitor: compare second lengths against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (rst_n) begin
        if (syncClear || !enable) lastMark = cyc;
        if (secTick) begin
          check(secClk == 1'b1, "R3 secClk high at secTick", int'(secClk), 1);
          if (expQ.size() == 0) begin
            check(1'b0, "R8/R1 unexpected secTick", cyc - lastMark, 0);
          end else begin
            int e;
            e = expQ.pop_front();
            if (e >= 0) check(cyc - lastMark == e, "R1/R4/R5/R6/R7/R9 second length", cyc - lastMark, e);
          end
          lastMark = cyc;
        end
      end
    end
  end

  task automatic doClear(input logic [7:0] c);
    @(negedge clk);
    calValue  = c;
    syncClear = 1'b1;
    @(negedge clk);
    syncClear = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runCal(input logic [7:0] c, input int n);
    int adj;
    adj = 4 * int'($signed(c));
    doClear(c);
    for (int i = 1; i <= n; i++)
      expQ.push_back((i > 1 && (i - 1) % S == 0) ? P - adj : P);
    waitDrain();
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R10: power-on reset state
    check(secTick == 1'b0, "R10 secTick", int'(secTick), 0);
    check(halfTick == 1'b0, "R10 halfTick", int'(halfTick), 0);
    check(halfSec == 1'b0, "R10 halfSec", int'(halfSec), 0);
    check(secClk == 1'b1, "R10 secClk", int'(secClk), 1);

    @(negedge clk);
    enable = 1'b1;

    // R1: nominal, no trim
    runCal(8'h00, 4);

    // R2 / R3: probe around the half-second point
    @(negedge clk);
    syncClear = 1'b1;
    @(posedge clk);
    #1;
    check(halfSec == 1'b0 && secClk == 1'b1, "R2 halfSec at count 0", int'(halfSec), 0);
    @(negedge clk);
    syncClear = 1'b0;
    expQ.push_back(P);
    repeat (P / 2 - 1) @(posedge clk);
    #1;
    check(halfSec == 1'b0, "R2 halfSec before half", int'(halfSec), 0);
    check(halfTick == 1'b0, "R2 halfTick before half", int'(halfTick), 0);
    @(posedge clk);
    #1;
    check(halfSec == 1'b1, "R2 halfSec at half", int'(halfSec), 1);
    check(halfTick == 1'b1, "R2 halfTick at half", int'(halfTick), 1);
    check(secClk == 1'b0, "R3 secClk low in second half", int'(secClk), 0);
    @(posedge clk);
    #1;
    check(halfTick == 1'b0, "R2 halfTick one cycle", int'(halfTick), 0);
    waitDrain();

    // R4: positive trim
    runCal(8'h01, 7);
    runCal(8'h7F, 4);
    // R5: negative trim
    runCal(8'hFF, 4);
    runCal(8'h80, 4);

    // R6: trim changed mid-minute lands at the boundary only
    doClear(8'h00);
    expQ.push_back(P); expQ.push_back(P); expQ.push_back(P); expQ.push_back(P - 64);
    repeat (P + P / 2) @(negedge clk);
    calValue = 8'h10;
    waitDrain();

    // R7: clear in the middle of a second
    repeat (300) @(negedge clk);
    doClear(8'h00);
    expQ.push_back(P);
    waitDrain();

    // R7: clear while a swallow is pending
    runCal(8'h80, 3);
    repeat (100) @(negedge clk);
    doClear(8'h00);
    expQ.push_back(P); expQ.push_back(P);
    waitDrain();

    // R8: disabled for a long stretch, then restart from zero
    @(negedge clk);
    enable   = 1'b0;
    calValue = 8'h10;
    for (int k = 0; k < 3; k++) begin
      repeat (1000) @(negedge clk);
      check(halfSec == 1'b0, "R8 halfSec held while disabled", int'(halfSec), 0);
      check(secClk == 1'b1, "R8 secClk held while disabled", int'(secClk), 1);
    end
    @(negedge clk);
    enable = 1'b1;
    expQ.push_back(P); expQ.push_back(P); expQ.push_back(P); expQ.push_back(P - 64);
    waitDrain();

    // R9: input pulses at half rate
    halfRate = 1'b1;
    doClear(8'h00);
    expQ.push_back(-1); expQ.push_back(2 * P); expQ.push_back(2 * P);
    waitDrain();
    halfRate = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule